// File: doc/BRIEF.md
# Chained-Status Interrupt Aggregator

A chain of plug-in modules reports one status byte per module over a serial shift-register chain, and a few bits of each byte carry interrupt state. All modules also share one interrupt wire. This block turns those buried status bits into sixteen separately maskable, sticky pending lines. When the shared wire is high, the block asks the chain controller for a fresh read of every module byte. When the controller hands back the bytes, each configured source picks its own bit and marks itself pending if the bit shows an active interrupt.

Software describes each source by writing a (module slot, bit number) pair into a mapping table. Only the upper nibble of a status byte may carry interrupt bits. A mapping that points elsewhere, or at a slot past the end of the chain, leaves that source non-existent. Pending bits stay set until software writes ones to clear them, and a single OR output signals that any source is pending. The serial transfer and the discovery of which modules are fitted are handled by other blocks. The fixed source numbers are declared in the package for use by software and benches: PCI bridge 0, USB3 4, eight-port switch number n at 8+n, four-port switch 12.

Top module: `irq_chain_agg`

## Requirements
- R1: After reset, pending is 0, irq_out is 0 and rd_req is 0. All sources are masked (mask bit 1 = masked) and no source exists, so a read that returns all-zero bytes sets nothing.
- R2: A high shared_irq while no read is outstanding produces rd_req high for exactly one cycle, in the cycle after it is sampled.
- R3: A rd_done sampled while a read is outstanding sets, in the next cycle, the pending bit of each existing, unmasked source whose mapped bit reads 0 (active-low). The byte of module slot k is rd_data[8k+7:8k].
- R4: A source that is masked or does not exist never becomes pending. A mask write replaces all 16 mask bits.
- R5: A mapping write (cfg_we with cfg_src, cfg_idx, cfg_bit) marks the source as existing only if cfg_bit is 4 to 7 and cfg_idx is below 10. Any other write clears its exists bit, so the source cannot become pending.
- R6: Pending bits are sticky. clr_we with clr_wdata clears the bits written as 1. When a bit is set by a read in the same cycle it is cleared, the set wins.
- R7: irq_out is high exactly when at least one pending bit is set.
- R8: If shared_irq is high in the cycle rd_done is accepted, rd_req is raised again in the next cycle. Otherwise no new request is made until shared_irq is seen high again.
- R9: rd_done while no read is outstanding is ignored: pending does not change.
- R10: Masking a source that is already pending leaves its pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shared_irq | input | 1 | Shared interrupt wire from all modules, active high |
| rd_req | output | 1 | One-cycle request for a full chain read |
| rd_done | input | 1 | Chain read finished; rd_data is valid this cycle |
| rd_data | input | 80 | Status bytes, slot k at bits 8k+7:8k |
| cfg_we | input | 1 | Mapping table write strobe |
| cfg_src | input | 4 | Source being mapped |
| cfg_idx | input | 4 | Module slot for the source |
| cfg_bit | input | 3 | Bit number within the slot's byte |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 16 | New mask, 1 = masked |
| clr_we | input | 1 | Pending clear strobe |
| clr_wdata | input | 16 | Pending bits to clear (write one to clear) |
| pending | output | 16 | Sticky pending bits per source |
| irq_out | output | 1 | OR of all pending bits |

## Verification
A wrong entry in the mapping table shows up as the wrong pending bit, or a missing one, in the cycle after the next accepted rd_done. A stale exists or mask bit shows up the same way. A request state machine stuck in the wrong state shows up within a cycle, either as a missing or doubled rd_req or as a read result that is dropped. Because pending is sticky, a wrongly set bit stays visible at the ports until it is cleared, so every read in the bench is checked against a model that tracks mapping, mask and pending.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } agg_state_e;

   // fixed source numbers for the known module kinds
   localparam int SRC_PCI      = 0;
   localparam int SRC_USB3     = 4;
   localparam int SRC_SW8_BASE = 8;
   localparam int SRC_SW4      = 12;

   function automatic int sw8_src(input int n);
      return SRC_SW8_BASE + n;
   endfunction

endpackage

// File: rtl/irq_agg_map.sv
module irq_agg_map #(
   parameter int NUM_SRC = 16,
   parameter int MAX_MOD = 10,
   parameter int BYTE_W  = 8,
   parameter int STAT_LO = 4,
   parameter int SRC_W   = 4,
   parameter int IDX_W   = 4,
   parameter int BIT_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [SRC_W-1:0]         cfg_src,
   input  logic [IDX_W-1:0]         cfg_idx,
   input  logic [BIT_W-1:0]         cfg_bit,
   output logic [NUM_SRC*IDX_W-1:0] map_idx,
   output logic [NUM_SRC*BIT_W-1:0] map_bit,
   output logic [NUM_SRC-1:0]       exists
);

   logic            entry_ok;
   logic [NUM_SRC-1:0] src_sel;

   always_comb begin
      entry_ok = (int'(cfg_bit) >= STAT_LO) && (int'(cfg_idx) < MAX_MOD);
      src_sel  = '0;
      if (int'(cfg_src) < NUM_SRC) src_sel[cfg_src] = cfg_we;
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            map_idx[s*IDX_W +: IDX_W] <= '0;
            map_bit[s*BIT_W +: BIT_W] <= '0;
            exists[s]                 <= 1'b0;
         end else if (src_sel[s]) begin
            map_idx[s*IDX_W +: IDX_W] <= cfg_idx;
            map_bit[s*BIT_W +: BIT_W] <= cfg_bit;
            exists[s]                 <= entry_ok;
         end
      end
   end

   // R5: a mapping into the low nibble never leaves the source existing
   p_low_bit_rejected_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (int'(cfg_bit) < STAT_LO)) |=> ((exists & $past(src_sel)) == '0));

   // R5: a slot past the chain end is rejected too
   p_bad_slot_rejected_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (int'(cfg_idx) >= MAX_MOD)) |=> ((exists & $past(src_sel)) == '0));

endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
   import irq_agg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic shared_irq,
   input  logic rd_done,
   output logic rd_req,
   output logic capture
);

   agg_state_e state_q, state_d;
   logic       req_d;

   always_comb begin
      state_d = state_q;
      req_d   = 1'b0;
      capture = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (shared_irq) begin
               state_d = ST_WAIT;
               req_d   = 1'b1;
            end
         end
         ST_WAIT: begin
            if (rd_done) begin
               capture = 1'b1;
               if (shared_irq) req_d   = 1'b1;
               else            state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rd_req  <= 1'b0;
      end else begin
         state_q <= state_d;
         rd_req  <= req_d;
      end
   end

   // R2: shared line seen while idle raises a request next cycle
   p_req_on_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && shared_irq) |=> rd_req);

   // R2: a request only ever stands while a read is outstanding
   p_req_while_waiting_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (state_q == ST_WAIT));

   // R8: line still high at completion asks again at once
   p_rereq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && rd_done && shared_irq) |=> (rd_req && state_q == ST_WAIT));

   // R8: line low at completion returns to idle without a request
   p_no_rereq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && rd_done && !shared_irq) |=> (!rd_req && state_q == ST_IDLE));

endmodule

// File: rtl/irq_agg_pend.sv
module irq_agg_pend #(
   parameter int NUM_SRC    = 16,
   parameter int MAX_MOD    = 10,
   parameter int BYTE_W     = 8,
   parameter int IDX_W      = 4,
   parameter int BIT_W      = 3,
   parameter bit ACTIVE_LOW = 1'b1,
   parameter bit SET_WINS   = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      capture,
   input  logic [MAX_MOD*BYTE_W-1:0] rd_data,
   input  logic [NUM_SRC*IDX_W-1:0]  map_idx,
   input  logic [NUM_SRC*BIT_W-1:0]  map_bit,
   input  logic [NUM_SRC-1:0]        exists,
   input  logic                      mask_we,
   input  logic [NUM_SRC-1:0]        mask_wdata,
   input  logic                      clr_we,
   input  logic [NUM_SRC-1:0]        clr_wdata,
   output logic [NUM_SRC-1:0]        pending
);

   logic [BYTE_W-1:0]  mod_byte [MAX_MOD];
   logic [NUM_SRC-1:0] active;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] hits;
   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] pend_d;

   for (genvar m = 0; m < MAX_MOD; m++) begin : g_slot
      assign mod_byte[m] = rd_data[m*BYTE_W +: BYTE_W];
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic [IDX_W-1:0]  ix;
      logic [BIT_W-1:0]  bx;
      logic [BYTE_W-1:0] sel_byte;
      logic              raw;
      assign ix = map_idx[s*IDX_W +: IDX_W];
      assign bx = map_bit[s*BIT_W +: BIT_W];
      always_comb begin
         if (int'(ix) < MAX_MOD) sel_byte = mod_byte[ix];
         else                    sel_byte = {BYTE_W{ACTIVE_LOW}};
      end
      assign raw = sel_byte[bx];
      if (ACTIVE_LOW) begin : g_low
         assign active[s] = ~raw;
      end else begin : g_high
         assign active[s] = raw;
      end
   end

   assign hits    = active & exists & ~mask_q & {NUM_SRC{capture}};
   assign clr_vec = clr_we ? clr_wdata : '0;

   if (SET_WINS) begin : g_set_first
      assign pend_d = (pending & ~clr_vec) | hits;
   end else begin : g_clr_first
      assign pend_d = (pending | hits) & ~clr_vec;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '1;
         pending <= '0;
      end else begin
         if (mask_we) mask_q <= mask_wdata;
         pending <= pend_d;
      end
   end

   // R6, R10: without a clear, no pending bit ever drops
   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((pending & $past(pending)) == $past(pending)));

   // R4: newly set bits only for existing, unmasked sources
   p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pending & ~$past(pending) & ($past(mask_q) | ~$past(exists))) == '0));

   // R9: no new pending bit without an accepted read
   p_no_capture_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> ((pending & ~$past(pending)) == '0));

endmodule

// File: rtl/irq_chain_agg.sv
module irq_chain_agg #(
   parameter int NUM_SRC    = 16,
   parameter int MAX_MOD    = 10,
   parameter int BYTE_W     = 8,
   parameter int STAT_LO    = 4,
   parameter bit ACTIVE_LOW = 1'b1,
   parameter bit SET_WINS   = 1'b1,
   localparam int SRC_W     = $clog2(NUM_SRC),
   localparam int IDX_W     = $clog2(MAX_MOD),
   localparam int BIT_W     = $clog2(BYTE_W),
   localparam int DATA_W    = MAX_MOD * BYTE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shared_irq,
   output logic               rd_req,
   input  logic               rd_done,
   input  logic [DATA_W-1:0]  rd_data,
   input  logic               cfg_we,
   input  logic [SRC_W-1:0]   cfg_src,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [BIT_W-1:0]   cfg_bit,
   input  logic               mask_we,
   input  logic [NUM_SRC-1:0] mask_wdata,
   input  logic               clr_we,
   input  logic [NUM_SRC-1:0] clr_wdata,
   output logic [NUM_SRC-1:0] pending,
   output logic               irq_out
);

   if (NUM_SRC < 2 || NUM_SRC > 16) begin : g_bad_src
      $error("irq_chain_agg: NUM_SRC must lie in 2..16");
   end
   if (MAX_MOD < 2) begin : g_bad_mod
      $error("irq_chain_agg: MAX_MOD must be at least 2");
   end
   if ((1 << BIT_W) != BYTE_W) begin : g_bad_byte
      $error("irq_chain_agg: BYTE_W must be a power of two");
   end
   if (STAT_LO < 0 || STAT_LO >= BYTE_W) begin : g_bad_lo
      $error("irq_chain_agg: STAT_LO must lie inside the byte");
   end

   logic [NUM_SRC*IDX_W-1:0] map_idx;
   logic [NUM_SRC*BIT_W-1:0] map_bit;
   logic [NUM_SRC-1:0]       exists;
   logic                     capture;

   irq_agg_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .shared_irq (shared_irq),
      .rd_done    (rd_done),
      .rd_req     (rd_req),
      .capture    (capture)
   );

   irq_agg_map #(
      .NUM_SRC (NUM_SRC), .MAX_MOD (MAX_MOD), .BYTE_W (BYTE_W),
      .STAT_LO (STAT_LO), .SRC_W (SRC_W), .IDX_W (IDX_W), .BIT_W (BIT_W)
   ) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (cfg_we),
      .cfg_src (cfg_src),
      .cfg_idx (cfg_idx),
      .cfg_bit (cfg_bit),
      .map_idx (map_idx),
      .map_bit (map_bit),
      .exists  (exists)
   );

   irq_agg_pend #(
      .NUM_SRC (NUM_SRC), .MAX_MOD (MAX_MOD), .BYTE_W (BYTE_W),
      .IDX_W (IDX_W), .BIT_W (BIT_W),
      .ACTIVE_LOW (ACTIVE_LOW), .SET_WINS (SET_WINS)
   ) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (capture),
      .rd_data    (rd_data),
      .map_idx    (map_idx),
      .map_bit    (map_bit),
      .exists     (exists),
      .mask_we    (mask_we),
      .mask_wdata (mask_wdata),
      .clr_we     (clr_we),
      .clr_wdata  (clr_wdata),
      .pending    (pending)
   );

   assign irq_out = |pending;

   // R7: the aggregate line never stays high with nothing pending after a clear
   p_irq_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && (clr_wdata == '1) && !capture) |=> !irq_out);

endmodule

// File: tb/irq_chain_agg_bench.sv
module irq_chain_agg_bench;
   import irq_agg_pkg::*;

   localparam int NS = 16;
   localparam int NM = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          shared_irq = 1'b0;
   logic          rd_req;
   logic          rd_done = 1'b0;
   logic [79:0]   rd_data = '1;
   logic          cfg_we = 1'b0;
   logic [3:0]    cfg_src = '0;
   logic [3:0]    cfg_idx = '0;
   logic [2:0]    cfg_bit = '0;
   logic          mask_we = 1'b0;
   logic [15:0]   mask_wdata = '0;
   logic          clr_we = 1'b0;
   logic [15:0]   clr_wdata = '0;
   logic [15:0]   pending;
   logic          irq_out;

   irq_chain_agg u_irq_chain_agg (
      .clk (clk), .rst_n (rst_n), .shared_irq (shared_irq), .rd_req (rd_req),
      .rd_done (rd_done), .rd_data (rd_data), .cfg_we (cfg_we), .cfg_src (cfg_src),
      .cfg_idx (cfg_idx), .cfg_bit (cfg_bit), .mask_we (mask_we),
      .mask_wdata (mask_wdata), .clr_we (clr_we), .clr_wdata (clr_wdata),
      .pending (pending), .irq_out (irq_out)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   // bench model
   int          m_idx [NS];
   int          m_bit [NS];
   logic [15:0] m_exist = '0;
   logic [15:0] m_mask  = '1;
   logic [15:0] m_pend  = '0;

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000) begin
         n_bad++;
         $display("FAIL watchdog: run hung, act cycles=%0d exp <= 50000", cyc);
         summary();
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] hits_of(input logic [79:0] d);
      logic [15:0] h = '0;
      for (int s = 0; s < NS; s++)
         if (m_exist[s] && !m_mask[s] && d[m_idx[s]*8 + m_bit[s]] == 1'b0) h[s] = 1'b1;
      return h;
   endfunction

   task automatic map_src(input int s, input int ix, input int bt);
      @(negedge clk);
      cfg_we = 1'b1; cfg_src = 4'(s); cfg_idx = 4'(ix); cfg_bit = 3'(bt);
      @(negedge clk);
      cfg_we = 1'b0;
      m_idx[s]   = (ix < NM) ? ix : 0;
      m_bit[s]   = bt;
      m_exist[s] = (bt >= 4) && (ix < NM);
   endtask

   task automatic set_mask(input logic [15:0] mk);
      @(negedge clk);
      mask_we = 1'b1; mask_wdata = mk;
      @(negedge clk);
      mask_we = 1'b0;
      m_mask = mk;
      chk(pending == m_pend, "R10 mask write keeps pending", pending, m_pend);
   endtask

   task automatic clear(input logic [15:0] cv);
      @(negedge clk);
      clr_we = 1'b1; clr_wdata = cv;
      @(negedge clk);
      clr_we = 1'b0;
      m_pend = m_pend & ~cv;
      chk(pending == m_pend, "R6 write-one-to-clear", pending, m_pend);
      chk(irq_out == (m_pend != 0), "R7 irq_out is OR of pending", irq_out, m_pend != 0);
   endtask

   // full read cycle; keep=1 holds the shared line through completion
   task automatic do_read(input logic [79:0] d, input bit keep, input logic [15:0] cv);
      @(negedge clk);
      shared_irq = 1'b1;
      @(negedge clk);
      chk(rd_req == 1'b1, "R2 request after shared line", rd_req, 1);
      shared_irq = keep;
      @(negedge clk);
      chk(rd_req == 1'b0, "R2 request lasts one cycle", rd_req, 0);
      rd_done = 1'b1; rd_data = d;
      clr_we = (cv != 0); clr_wdata = cv;
      @(negedge clk);
      rd_done = 1'b0; clr_we = 1'b0; rd_data = '1;
      m_pend = (m_pend & ~cv) | hits_of(d);
      chk(pending == m_pend, "R3 pending after read", pending, m_pend);
      chk(irq_out == (m_pend != 0), "R7 irq_out is OR of pending", irq_out, m_pend != 0);
      if (keep) begin
         chk(rd_req == 1'b1, "R8 re-request while line high", rd_req, 1);
         shared_irq = 1'b0;
         @(negedge clk);
         rd_done = 1'b1;
         @(negedge clk);
         rd_done = 1'b0;
         chk(pending == m_pend, "R8 idle second read adds nothing", pending, m_pend);
      end
      chk(rd_req == 1'b0, "R8 no request with line low", rd_req, 0);
   endtask

   initial begin
      logic [79:0] d;
      for (int s = 0; s < NS; s++) begin m_idx[s] = 0; m_bit[s] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pending == 16'h0, "R1 reset pending", pending, 0);
      chk(irq_out == 1'b0, "R1 reset irq_out", irq_out, 0);
      chk(rd_req == 1'b0, "R1 reset rd_req", rd_req, 0);
      do_read('0, 1'b0, '0);                       // R1: nothing exists, all masked

      map_src(SRC_PCI, 0, 4);
      map_src(SRC_USB3, 1, 7);
      map_src(sw8_src(0), 2, 5);
      map_src(sw8_src(1), 9, 4);
      map_src(SRC_SW4, 3, 6);
      do_read('0, 1'b0, '0);                       // R4: mapped but masked
      chk(pending == 16'h0, "R4 masked sources stay quiet", pending, 0);

      map_src(1, 0, 2);                            // R5: low nibble rejected
      map_src(2, 12, 5);                           // R5: slot past chain end
      set_mask(16'h0000);
      do_read('0, 1'b0, '0);
      chk(pending == 16'h1311, "R5 only valid mappings pend", pending, 16'h1311);
      clear(16'hffff);

      d = '1; d[1*8 + 7] = 1'b0;                   // R3: only USB3 active
      do_read(d, 1'b0, '0);
      chk(pending == 16'h0010, "R3 single active-low bit", pending, 16'h0010);

      map_src(SRC_USB3, 1, 1);                     // R5: remap to low bit drops exists
      clear(16'hffff);
      do_read('0, 1'b0, '0);
      chk(pending[4] == 1'b0, "R5 remapped source no longer exists", pending[4], 0);

      set_mask(16'hffff);                          // R10
      chk(pending == 16'h1301, "R10 masking keeps pending", pending, 16'h1301);

      clear(16'h0300);
      set_mask(16'h0000);
      d = '1; d[9*8 + 4] = 1'b0;                   // R6: set and clear collide
      do_read(d, 1'b0, 16'h0200);
      chk(pending[9] == 1'b1, "R6 set wins over clear", pending[9], 1);

      do_read('0, 1'b1, '0);                       // R8

      @(negedge clk);                              // R9: stray completion
      clear(16'hffff);
      rd_done = 1'b1; rd_data = '0;
      @(negedge clk);
      rd_done = 1'b0; rd_data = '1;
      @(negedge clk);
      chk(pending == 16'h0, "R9 stray rd_done ignored", pending, 0);
      chk(rd_req == 1'b0, "R9 stray rd_done no request", rd_req, 0);

      void'($urandom(32'd1234));
      for (int it = 0; it < 80; it++) begin
         int op = $urandom_range(0, 5);
         case (op)
            0: map_src($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 7));
            1: set_mask(16'($urandom));
            2: clear(16'($urandom));
            default: begin
               for (int w = 0; w < 3; w++) d[w*32 +: 32] = $urandom;
               do_read(d, 1'($urandom_range(0, 1)), (op == 5) ? 16'($urandom) : 16'h0);
            end
         endcase
      end
      summary();
   end

endmodule